// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a two-part logical address (segment number plus offset) into a physical address. It holds a small segment table that software fills through a configuration port. Every entry carries a base address, a length (the limit), a valid flag and three permission flags for read, write and instruction fetch. A separate length register says how many segment numbers are currently legal.

A request carries the segment number, the offset and the access type, and it is accepted with a valid/ready handshake. One cycle after acceptance the block returns either the physical address `base + offset` or a trap with a 2-bit fault code. The checks run in a fixed priority and only the first failing one is reported. A single translation is in flight at a time: the request side is not ready while a response is being presented.

Top module: `seg_xlate_unit`

## Requirements
- R1: A request with segment number below the length register, a valid entry, offset below the entry limit and a permitted access type returns rsp_fault_o=0 and rsp_paddr_o = base + offset (truncated to PA_W bits).
- R2: A segment number greater than or equal to the length register traps with code 0 (bad segment), whatever the entry holds; this check has the highest priority.
- R3: A legal segment number whose entry has its valid flag at 0 traps with code 1 (invalid entry), ahead of the limit and permission checks.
- R4: An offset greater than or equal to the entry limit traps with code 2 (limit exceeded), ahead of the permission check; offset limit-1 is still accepted.
- R5: Access type encoding is 0 read, 1 write, 2 execute, 3 reserved; permission bit 0 allows read, bit 1 write, bit 2 execute. An access whose bit is clear, or any access of type 3, traps with code 3 (protection violation).
- R6: Whenever a response traps, rsp_paddr_o is 0.
- R7: A request is accepted on a clock edge where req_valid_i and req_ready_o are both 1; rsp_valid_o is 1 for exactly the following cycle, and req_ready_o is 0 during that cycle. No response appears without an accepted request.
- R8: An entry write to an index greater than or equal to NUM_SEGS changes no entry.
- R9: A segment number that is below the length register but greater than or equal to NUM_SEGS traps with code 1 (invalid entry).
- R10: After reset the length register is 0 and all entries are invalid, so every request traps with code 0 until the length register is written; req_ready_o is 1 and rsp_valid_o is 0.
- R11: A length register write applies to the next accepted request; lowering it makes previously legal segment numbers trap with code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_ent_we_i | input | 1 | Write one segment-table entry |
| cfg_idx_i | input | IDX_W | Entry index to write |
| cfg_base_i | input | PA_W | Base physical address of the entry |
| cfg_limit_i | input | OFF_W | Segment length |
| cfg_valid_i | input | 1 | Entry valid flag |
| cfg_perm_i | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| cfg_len_we_i | input | 1 | Write the length register |
| cfg_len_i | input | IDX_W | New number of legal segments |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block can accept a request |
| req_seg_i | input | IDX_W | Segment number |
| req_off_i | input | OFF_W | Offset within the segment |
| req_acc_i | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid_o | output | 1 | Response present for this cycle |
| rsp_fault_o | output | 1 | Response is a trap |
| rsp_code_o | output | 2 | Fault code: 0 bad segment, 1 invalid, 2 limit, 3 protection |
| rsp_paddr_o | output | PA_W | Physical address, 0 on a trap |

## Verification
The hardest cases are those where several checks fail at once, since only the first in priority may show: an invalid entry that is also overrun, an overrun that is also a protection fault, and a segment number that passes the length check but has no storage behind it. The stimulus reaches them by programming entries whose flags and limits deliberately conflict, raising the length register above the table depth, and writing to indices past the end of the table before translating through the same segment numbers and through untouched neighbours.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    FLT_BAD_SEG = 2'd0,
    FLT_INVALID = 2'd1,
    FLT_LIMIT   = 2'd2,
    FLT_PROT    = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;
  localparam int PERM_N = 3;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int NUM_SEGS = 6,
  parameter int IDX_W    = 4,
  parameter int OFF_W    = 16,
  parameter int PA_W     = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ent_we_i,
  input  logic [IDX_W-1:0] ent_idx_i,
  input  logic [PA_W-1:0]  ent_base_i,
  input  logic [OFF_W-1:0] ent_limit_i,
  input  logic             ent_valid_i,
  input  logic [2:0]       ent_perm_i,
  input  logic             len_we_i,
  input  logic [IDX_W-1:0] len_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [PA_W-1:0]  rd_base_o,
  output logic [OFF_W-1:0] rd_limit_o,
  output logic             rd_valid_o,
  output logic [2:0]       rd_perm_o,
  output logic [IDX_W-1:0] len_o
);

  logic [PA_W-1:0]     base_q  [NUM_SEGS];
  logic [OFF_W-1:0]    limit_q [NUM_SEGS];
  logic [2:0]          perm_q  [NUM_SEGS];
  logic [NUM_SEGS-1:0] valid_q;
  logic [IDX_W-1:0]    len_q;

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_ent
    logic hit;
    assign hit = ent_we_i && (ent_idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[g]  <= '0;
        limit_q[g] <= '0;
        perm_q[g]  <= '0;
        valid_q[g] <= 1'b0;
      end else if (hit) begin
        base_q[g]  <= ent_base_i;
        limit_q[g] <= ent_limit_i;
        perm_q[g]  <= ent_perm_i;
        valid_q[g] <= ent_valid_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       len_q <= '0;
    else if (len_we_i) len_q <= len_i;
  end

  // indices past the table read as an invalid, all-zero entry
  always_comb begin
    rd_base_o  = '0;
    rd_limit_o = '0;
    rd_perm_o  = '0;
    rd_valid_o = 1'b0;
    for (int k = 0; k < NUM_SEGS; k++) begin
      if (rd_idx_i == IDX_W'(k)) begin
        rd_base_o  = base_q[k];
        rd_limit_o = limit_q[k];
        rd_perm_o  = perm_q[k];
        rd_valid_o = valid_q[k];
      end
    end
  end

  assign len_o = len_q;

  AST_OOR_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ent_we_i && (ent_idx_i >= IDX_W'(NUM_SEGS))) |=> $stable(valid_q)); // R8

endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int OFF_W = 16,
  parameter int PA_W  = 20
) (
  input  logic [IDX_W-1:0] seg_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       acc_i,
  input  logic [IDX_W-1:0] len_i,
  input  logic [PA_W-1:0]  base_i,
  input  logic [OFF_W-1:0] limit_i,
  input  logic             valid_i,
  input  logic [2:0]       perm_i,
  output logic             fault_o,
  output logic [1:0]       code_o,
  output logic [PA_W-1:0]  paddr_o
);

  logic acc_ok;

  always_comb begin
    unique case (acc_e'(acc_i))
      ACC_READ:  acc_ok = perm_i[PERM_R];
      ACC_WRITE: acc_ok = perm_i[PERM_W];
      ACC_EXEC:  acc_ok = perm_i[PERM_X];
      default:   acc_ok = 1'b0;
    endcase
  end

  // first failing check wins
  always_comb begin
    fault_o = 1'b1;
    code_o  = FLT_BAD_SEG;
    paddr_o = '0;
    if (seg_i >= len_i) begin
      code_o = FLT_BAD_SEG;
    end else if (!valid_i) begin
      code_o = FLT_INVALID;
    end else if (off_i >= limit_i) begin
      code_o = FLT_LIMIT;
    end else if (!acc_ok) begin
      code_o = FLT_PROT;
    end else begin
      fault_o = 1'b0;
      code_o  = FLT_BAD_SEG;
      paddr_o = base_i + PA_W'(off_i);
    end
  end

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEGS = 6,
  parameter int OFF_W    = 16,
  parameter int PA_W     = 20,
  localparam int IDX_W   = $clog2(NUM_SEGS) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_ent_we_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic [PA_W-1:0]  cfg_base_i,
  input  logic [OFF_W-1:0] cfg_limit_i,
  input  logic             cfg_valid_i,
  input  logic [2:0]       cfg_perm_i,
  input  logic             cfg_len_we_i,
  input  logic [IDX_W-1:0] cfg_len_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [IDX_W-1:0] req_seg_i,
  input  logic [OFF_W-1:0] req_off_i,
  input  logic [1:0]       req_acc_i,
  output logic             rsp_valid_o,
  output logic             rsp_fault_o,
  output logic [1:0]       rsp_code_o,
  output logic [PA_W-1:0]  rsp_paddr_o
);

  logic [PA_W-1:0]  ent_base;
  logic [OFF_W-1:0] ent_limit;
  logic             ent_valid;
  logic [2:0]       ent_perm;
  logic [IDX_W-1:0] len;
  logic             chk_fault;
  logic [1:0]       chk_code;
  logic [PA_W-1:0]  chk_paddr;
  logic             accept;
  logic             rsp_valid_q;
  logic             rsp_fault_q;
  logic [1:0]       rsp_code_q;
  logic [PA_W-1:0]  rsp_paddr_q;

  seg_table #(
    .NUM_SEGS(NUM_SEGS), .IDX_W(IDX_W), .OFF_W(OFF_W), .PA_W(PA_W)
  ) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ent_we_i    (cfg_ent_we_i),
    .ent_idx_i   (cfg_idx_i),
    .ent_base_i  (cfg_base_i),
    .ent_limit_i (cfg_limit_i),
    .ent_valid_i (cfg_valid_i),
    .ent_perm_i  (cfg_perm_i),
    .len_we_i    (cfg_len_we_i),
    .len_i       (cfg_len_i),
    .rd_idx_i    (req_seg_i),
    .rd_base_o   (ent_base),
    .rd_limit_o  (ent_limit),
    .rd_valid_o  (ent_valid),
    .rd_perm_o   (ent_perm),
    .len_o       (len)
  );

  seg_check #(
    .IDX_W(IDX_W), .OFF_W(OFF_W), .PA_W(PA_W)
  ) u_check (
    .seg_i   (req_seg_i),
    .off_i   (req_off_i),
    .acc_i   (req_acc_i),
    .len_i   (len),
    .base_i  (ent_base),
    .limit_i (ent_limit),
    .valid_i (ent_valid),
    .perm_i  (ent_perm),
    .fault_o (chk_fault),
    .code_o  (chk_code),
    .paddr_o (chk_paddr)
  );

  // one in flight: block new requests while a response is shown
  assign req_ready_o = !rsp_valid_q;
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= 1'b0;
      rsp_code_q  <= '0;
      rsp_paddr_q <= '0;
    end else begin
      rsp_valid_q <= accept;
      if (accept) begin
        rsp_fault_q <= chk_fault;
        rsp_code_q  <= chk_code;
        rsp_paddr_q <= chk_paddr;
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_fault_o = rsp_fault_q;
  assign rsp_code_o  = rsp_code_q;
  assign rsp_paddr_o = rsp_paddr_q;

  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> rsp_valid_o); // R7
  AST_NO_RSP_UNASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_ready_o) |=> !rsp_valid_o); // R7
  AST_SINGLE_FLIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o); // R7
  AST_TRAP_NO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o) |-> (rsp_paddr_o == '0)); // R6
  AST_BAD_SEG_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && (req_seg_i >= len)) |=> (rsp_fault_o && rsp_code_o == FLT_BAD_SEG)); // R2
  AST_OK_IN_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !chk_fault) |-> (req_off_i < ent_limit)); // R4

endmodule

// File: tb/seg_xlate_unit_bench.sv
module seg_xlate_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_SEGS = 6;
  localparam int OFF_W = 16;
  localparam int PA_W = 20;
  localparam int IDX_W = 4;

  typedef struct packed {
    logic [IDX_W-1:0] seg;
    logic [OFF_W-1:0] off;
    logic [1:0]       acc;
    logic             flt;
    logic [1:0]       code;
    logic [PA_W-1:0]  pa;
  } vec_t;

  // acc: 0 read, 1 write, 2 exec, 3 reserved; codes 0 seg,1 invalid,2 limit,3 prot
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  16'd999,    2'd0, 1'b0, 2'd0, 20'd2399},   // R1 R4 boundary
    '{4'd0,  16'd1000,   2'd0, 1'b1, 2'd2, 20'd0},      // R4
    '{4'd1,  16'd53,     2'd2, 1'b0, 2'd0, 20'd4353},   // R1
    '{4'd1,  16'd53,     2'd1, 1'b1, 2'd3, 20'd0},      // R5
    '{4'd2,  16'd0,      2'd0, 1'b1, 2'd1, 20'd0},      // R3
    '{4'd2,  16'd5,      2'd1, 1'b1, 2'd1, 20'd0},      // R3 over limit
    '{4'd4,  16'd0,      2'd0, 1'b1, 2'd0, 20'd0},      // R2
    '{4'd15, 16'd0,      2'd0, 1'b1, 2'd0, 20'd0},      // R2
    '{4'd0,  16'd2000,   2'd2, 1'b1, 2'd2, 20'd0},      // R4 before R5
    '{4'd3,  16'hFFFE,   2'd1, 1'b0, 2'd0, 20'h8FFFE},  // R1
    '{4'd3,  16'd0,      2'd0, 1'b1, 2'd3, 20'd0},      // R5
    '{4'd0,  16'd0,      2'd3, 1'b1, 2'd3, 20'd0},      // R5 reserved
    '{4'd1,  16'd400,    2'd3, 1'b1, 2'd2, 20'd0}       // R4 before R5
  };

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cfg_ent_we = 1'b0;
  logic [IDX_W-1:0] cfg_idx = '0;
  logic [PA_W-1:0]  cfg_base = '0;
  logic [OFF_W-1:0] cfg_limit = '0;
  logic             cfg_valid = 1'b0;
  logic [2:0]       cfg_perm = '0;
  logic             cfg_len_we = 1'b0;
  logic [IDX_W-1:0] cfg_len = '0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [IDX_W-1:0] req_seg = '0;
  logic [OFF_W-1:0] req_off = '0;
  logic [1:0]       req_acc = '0;
  logic             rsp_valid;
  logic             rsp_fault;
  logic [1:0]       rsp_code;
  logic [PA_W-1:0]  rsp_paddr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_xlate_unit #(.NUM_SEGS(NUM_SEGS), .OFF_W(OFF_W), .PA_W(PA_W)) u_seg_xlate_unit (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_ent_we_i(cfg_ent_we), .cfg_idx_i(cfg_idx), .cfg_base_i(cfg_base),
    .cfg_limit_i(cfg_limit), .cfg_valid_i(cfg_valid), .cfg_perm_i(cfg_perm),
    .cfg_len_we_i(cfg_len_we), .cfg_len_i(cfg_len),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_seg_i(req_seg),
    .req_off_i(req_off), .req_acc_i(req_acc),
    .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault), .rsp_code_o(rsp_code),
    .rsp_paddr_o(rsp_paddr)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr_ent(input int idx, input int base, input int lim, input bit v, input int perm);
    @(negedge clk);
    cfg_ent_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_base = PA_W'(base);
    cfg_limit = OFF_W'(lim); cfg_valid = v; cfg_perm = 3'(perm);
    @(negedge clk);
    cfg_ent_we = 1'b0;
  endtask

  task automatic wr_len(input int n);
    @(negedge clk);
    cfg_len_we = 1'b1; cfg_len = IDX_W'(n);
    @(negedge clk);
    cfg_len_we = 1'b0;
  endtask

  // drive, accept at next edge, sample the response at the following negedge
  task automatic xlate(input int seg, input int off, input int acc);
    @(negedge clk);
    req_valid = 1'b1; req_seg = IDX_W'(seg); req_off = OFF_W'(off); req_acc = 2'(acc);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // packs {valid, fault, code, paddr}
  function automatic logic [31:0] rsp_word();
    return {8'd0, rsp_valid, rsp_fault, rsp_code, rsp_paddr};
  endfunction

  function automatic logic [31:0] exp_word(input bit f, input int c, input int pa);
    return {8'd0, 1'b1, f, 2'(c), PA_W'(pa)};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 ready after reset", 32'(req_ready), 32'd1);
    chk("R10 no rsp after reset", 32'(rsp_valid), 32'd0);
    rst_ni = 1'b1;

    xlate(0, 0, 0);
    chk("R10 len zero traps bad seg", rsp_word(), exp_word(1'b1, 0, 0));
    wr_len(4);
    xlate(0, 0, 0);
    chk("R10 entries invalid after reset", rsp_word(), exp_word(1'b1, 1, 0));

    wr_ent(0, 1400, 1000, 1'b1, 3'b011);
    wr_ent(1, 4300, 400, 1'b1, 3'b101);
    wr_ent(2, 3200, 3, 1'b0, 3'b111);
    wr_ent(3, 20'h80000, 16'hFFFF, 1'b1, 3'b010);

    for (int i = 0; i < NV; i++) begin
      xlate(int'(VECS[i].seg), int'(VECS[i].off), int'(VECS[i].acc));
      chk($sformatf("R1-vec %0d (R2 R3 R4 R5 R6)", i), rsp_word(),
          exp_word(VECS[i].flt, int'(VECS[i].code), int'(VECS[i].pa)));
    end

    // R7 handshake timing
    @(negedge clk);
    req_valid = 1'b1; req_seg = 4'd1; req_off = 16'd10; req_acc = 2'd0;
    @(negedge clk);
    chk("R7 rsp one cycle after accept", 32'(rsp_valid), 32'd1);
    chk("R7 not ready while rsp shown", 32'(req_ready), 32'd0);
    chk("R7 paddr", 32'(rsp_paddr), 32'd4310);
    req_seg = 4'd0; req_off = 16'd7;
    @(negedge clk);
    chk("R7 rsp lasts one cycle", 32'(rsp_valid), 32'd0);
    chk("R7 ready again", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 held request accepted next", rsp_word(), exp_word(1'b0, 0, 1407));
    @(negedge clk);
    @(negedge clk);
    chk("R7 no rsp without request", 32'(rsp_valid), 32'd0);

    // R8 and R9: writes past the table and segments past the table
    wr_ent(6, 20'h12345, 100, 1'b1, 3'b111);
    wr_ent(15, 20'h54321, 100, 1'b1, 3'b111);
    wr_len(7);
    xlate(6, 0, 0);
    chk("R8 R9 seg 6 stays invalid", rsp_word(), exp_word(1'b1, 1, 0));
    xlate(0, 999, 1);
    chk("R8 entry 0 untouched", rsp_word(), exp_word(1'b0, 0, 2399));
    xlate(2, 0, 0);
    chk("R8 entry 2 untouched", rsp_word(), exp_word(1'b1, 1, 0));
    xlate(7, 0, 0);
    chk("R2 seg equal to len", rsp_word(), exp_word(1'b1, 0, 0));

    // R11 lowering the length register
    wr_len(1);
    xlate(1, 53, 2);
    chk("R11 seg1 now bad", rsp_word(), exp_word(1'b1, 0, 0));
    xlate(0, 5, 0);
    chk("R11 seg0 still legal", rsp_word(), exp_word(1'b0, 0, 1405));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule